// File: doc/BRIEF.md
# Translation Unit Control and Status Register File

This block is the software-facing register file of an address translation unit. A simple single-cycle register port lets software load the page directory base, issue numbered commands, read the unit's status and the address of the most recent translation fault, invalidate one cached page or the whole translation cache, and manage a small interrupt set made of raw, clear, mask and masked-status registers.

Towards the translation datapath the block drives level control outputs (paging enable and stall request) and one-cycle strobes (invalidate all, invalidate one page, fault handled). It takes in fault and bus-error events, the faulting address, direction and master ID, and the datapath's idle and replay-empty indications. A hard-reset command returns every register to its power-on value without toggling the reset pin.

Top module: `mmu_csr`

## Requirements
- R1: The directory base register at offset 0x00 stores only bits [31:12] of a write; bits [11:0] always read as zero (a write of 0xCAFEBABE reads back 0xCAFEB000). It resets to zero.
- R2: Command word 0 (written to offset 0x08) sets paging and command word 1 clears it; status bit 0 and the `paging_en` output change at the clock edge that accepts the write.
- R3: Command word 2 raises `stall_req` at the accepting edge; status bit 2 (stall active) becomes set only on a later edge at which `dp_idle` is high; command word 3 clears both together. Status bit 31 is always the inverse of bit 2.
- R4: Command word 2 has no effect while status bit 1 (fault active) is set.
- R5: A `dp_fault` event sets status bit 1, stores the faulting address (readable at 0x0C), places the direction in status bit 5 (1 = write) and the master ID in status bits [10:6], and sets raw interrupt bit 0.
- R6: Command word 5 clears status bit 1 and pulses `fault_done` for exactly one cycle.
- R7: A `dp_bus_err` event sets raw interrupt bit 1 (raw at 0x14). Writing ones to offset 0x18 clears the matching raw bits; an event in the same cycle wins over the clear.
- R8: Masked status at 0x20 equals raw AND mask (mask at 0x1C, bits [1:0]); `irq` is high exactly when any masked bit is set.
- R9: Command word 4 pulses `zap_all` for one cycle; a write to offset 0x10 pulses `zap_one` for one cycle with `zap_one_page` equal to bits [31:12] of the written value.
- R10: Command word 6 returns base, paging, stall, fault state, fault address, raw, mask and the gating register (0x24, bit 0) to zero.
- R11: Any command word other than 0 to 6 changes no state and raises no strobe.
- R12: Status bit 3 shows `dp_idle` and bit 4 shows `dp_replay_empty` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 8 | Register byte offset |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data for `csr_addr` (combinational) |
| dp_fault | input | 1 | Translation fault event |
| dp_fault_addr | input | 32 | Address that faulted |
| dp_fault_write | input | 1 | Faulting access was a write |
| dp_fault_bus_id | input | 5 | ID of the faulting master |
| dp_bus_err | input | 1 | Table-walk read bus error event |
| dp_idle | input | 1 | Datapath has no access in flight |
| dp_replay_empty | input | 1 | Datapath replay buffer is empty |
| paging_en | output | 1 | Translation enabled |
| stall_req | output | 1 | Request the datapath to stall |
| zap_all | output | 1 | One-cycle invalidate-everything strobe |
| zap_one | output | 1 | One-cycle invalidate-one-page strobe |
| zap_one_page | output | 20 | Page number for `zap_one` |
| fault_done | output | 1 | One-cycle fault-handled strobe |
| irq | output | 1 | Interrupt request |

## Verification
The bench aims at the stall handshake, where a design that reports stall active as soon as the command lands, without waiting for an idle datapath, would let software touch the tables under live traffic, and at the refused stall during an active fault, where a wrong design would deadlock by stalling a unit waiting for its fault handler. It drives events in the same cycle as clear writes, since a design that lets the clear win would silently lose an interrupt. It also checks that the base register masks its low bits, that undefined command words do nothing, and that the hard-reset command clears every register, where a partial reset would leave a stale mask or base behind.

// File: rtl/mmu_csr_pkg.sv
package mmu_csr_pkg;

    localparam int unsigned REG_W    = 32;
    localparam int unsigned BUS_ID_W = 5;
    localparam int unsigned IRQ_N    = 2;

    // register byte offsets
    localparam logic [7:0] OFS_BASE  = 8'h00;
    localparam logic [7:0] OFS_STAT  = 8'h04;
    localparam logic [7:0] OFS_CMD   = 8'h08;
    localparam logic [7:0] OFS_FADDR = 8'h0C;
    localparam logic [7:0] OFS_ZAP1  = 8'h10;
    localparam logic [7:0] OFS_RAW   = 8'h14;
    localparam logic [7:0] OFS_ICLR  = 8'h18;
    localparam logic [7:0] OFS_IMASK = 8'h1C;
    localparam logic [7:0] OFS_ISTAT = 8'h20;
    localparam logic [7:0] OFS_GATE  = 8'h24;

    // status word bit positions
    localparam int unsigned ST_PAGING   = 0;
    localparam int unsigned ST_FAULT    = 1;
    localparam int unsigned ST_STALL    = 2;
    localparam int unsigned ST_IDLE     = 3;
    localparam int unsigned ST_REPLAY   = 4;
    localparam int unsigned ST_FWRITE   = 5;
    localparam int unsigned ST_BUSID    = 6;
    localparam int unsigned ST_NOSTALL  = 31;

    // interrupt bit positions
    localparam int unsigned IRQ_FAULT  = 0;
    localparam int unsigned IRQ_BUSERR = 1;

    typedef enum logic [2:0] {
        OP_PAGE_ON    = 3'd0,
        OP_PAGE_OFF   = 3'd1,
        OP_STALL_ON   = 3'd2,
        OP_STALL_OFF  = 3'd3,
        OP_ZAP_ALL    = 3'd4,
        OP_FAULT_DONE = 3'd5,
        OP_HARD_RST   = 3'd6
    } op_e;

    typedef struct packed {
        logic page_on;
        logic page_off;
        logic stall_on;
        logic stall_off;
        logic zap_all;
        logic fault_done;
        logic hard_rst;
    } op_strobe_t;

endpackage

// File: rtl/mmu_csr_cmd.sv
module mmu_csr_cmd
    import mmu_csr_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output op_strobe_t        ops
);

    localparam logic [ADDR_W-1:0] CMD_OFS = ADDR_W'(OFS_CMD);

    logic cmd_hit;

    assign cmd_hit = wr_en && (addr == CMD_OFS);

    // whole word must match a defined opcode; everything else is dropped
    always_comb begin
        ops = '0;
        if (cmd_hit) begin
            case (wdata)
                REG_W'(OP_PAGE_ON):    ops.page_on    = 1'b1;
                REG_W'(OP_PAGE_OFF):   ops.page_off   = 1'b1;
                REG_W'(OP_STALL_ON):   ops.stall_on   = 1'b1;
                REG_W'(OP_STALL_OFF):  ops.stall_off  = 1'b1;
                REG_W'(OP_ZAP_ALL):    ops.zap_all    = 1'b1;
                REG_W'(OP_FAULT_DONE): ops.fault_done = 1'b1;
                REG_W'(OP_HARD_RST):   ops.hard_rst   = 1'b1;
                default:               ops            = '0;
            endcase
        end
    end

endmodule

// File: rtl/mmu_csr_state.sv
module mmu_csr_state
    import mmu_csr_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  op_strobe_t          ops,
    input  logic                ev_fault,
    input  logic [REG_W-1:0]    ev_fault_addr,
    input  logic                ev_fault_write,
    input  logic [BUS_ID_W-1:0] ev_bus_id,
    input  logic                dp_idle,
    output logic                paging,
    output logic                stall_want,
    output logic                stall_act,
    output logic                fault_act,
    output logic                fault_write,
    output logic [BUS_ID_W-1:0] fault_bus_id,
    output logic [REG_W-1:0]    fault_addr,
    output logic                zap_all_p,
    output logic                fault_done_p
);

    typedef struct packed {
        logic                paging;
        logic                stall_want;
        logic                stall_act;
        logic                fault;
        logic                fwrite;
        logic [BUS_ID_W-1:0] bus_id;
        logic [REG_W-1:0]    faddr;
        logic                zap_all;
        logic                fdone;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.zap_all = 1'b0;
        st_d.fdone   = 1'b0;

        if (ops.page_on)  st_d.paging = 1'b1;
        if (ops.page_off) st_d.paging = 1'b0;

        // a stall request is refused while a fault awaits its handler
        if (ops.stall_on && !st_q.fault) st_d.stall_want = 1'b1;
        if (ops.stall_off)               st_d.stall_want = 1'b0;

        // acknowledged only once the request has been seen by an idle datapath
        st_d.stall_act = st_d.stall_want && st_q.stall_want
                         && (st_q.stall_act || dp_idle);

        st_d.zap_all = ops.zap_all;

        if (ops.fault_done) begin
            st_d.fault = 1'b0;
            st_d.fdone = 1'b1;
        end

        // a new fault outranks the handler's acknowledge in the same cycle
        if (ev_fault) begin
            st_d.fault  = 1'b1;
            st_d.fwrite = ev_fault_write;
            st_d.bus_id = ev_bus_id;
            st_d.faddr  = ev_fault_addr;
        end

        if (ops.hard_rst) st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign paging       = st_q.paging;
    assign stall_want   = st_q.stall_want;
    assign stall_act    = st_q.stall_act;
    assign fault_act    = st_q.fault;
    assign fault_write  = st_q.fwrite;
    assign fault_bus_id = st_q.bus_id;
    assign fault_addr   = st_q.faddr;
    assign zap_all_p    = st_q.zap_all;
    assign fault_done_p = st_q.fdone;

endmodule

// File: rtl/mmu_csr_intr.sv
module mmu_csr_intr #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hard_rst,
    input  logic [N-1:0] set_ev,
    input  logic         clr_we,
    input  logic [N-1:0] clr_bits,
    input  logic         mask_we,
    input  logic [N-1:0] mask_bits,
    output logic [N-1:0] raw,
    output logic [N-1:0] mask,
    output logic [N-1:0] masked,
    output logic         irq
);

    typedef struct packed {
        logic [N-1:0] raw;
        logic [N-1:0] mask;
    } irq_st_t;

    irq_st_t ir_d, ir_q;
    logic [N-1:0] raw_nxt;

    // per-cause next value: set beats write-one-to-clear
    for (genvar i = 0; i < N; i++) begin : g_cause
        always_comb begin
            if (set_ev[i])                    raw_nxt[i] = 1'b1;
            else if (clr_we && clr_bits[i])   raw_nxt[i] = 1'b0;
            else                              raw_nxt[i] = ir_q.raw[i];
        end
    end

    always_comb begin
        ir_d     = ir_q;
        ir_d.raw = raw_nxt;
        if (mask_we) ir_d.mask = mask_bits;
        if (hard_rst) ir_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ir_q <= '0;
        else        ir_q <= ir_d;
    end

    assign raw    = ir_q.raw;
    assign mask   = ir_q.mask;
    assign masked = ir_q.raw & ir_q.mask;
    assign irq    = |masked;

endmodule

// File: rtl/mmu_csr.sv
module mmu_csr
    import mmu_csr_pkg::*;
#(
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned PAGE_SHIFT = 12
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        csr_we,
    input  logic [ADDR_W-1:0]           csr_addr,
    input  logic [REG_W-1:0]            csr_wdata,
    output logic [REG_W-1:0]            csr_rdata,
    input  logic                        dp_fault,
    input  logic [REG_W-1:0]            dp_fault_addr,
    input  logic                        dp_fault_write,
    input  logic [BUS_ID_W-1:0]         dp_fault_bus_id,
    input  logic                        dp_bus_err,
    input  logic                        dp_idle,
    input  logic                        dp_replay_empty,
    output logic                        paging_en,
    output logic                        stall_req,
    output logic                        zap_all,
    output logic                        zap_one,
    output logic [REG_W-PAGE_SHIFT-1:0] zap_one_page,
    output logic                        fault_done,
    output logic                        irq
);

    localparam int unsigned PFN_W = REG_W - PAGE_SHIFT;

    localparam logic [ADDR_W-1:0] A_BASE  = ADDR_W'(OFS_BASE);
    localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_FADDR = ADDR_W'(OFS_FADDR);
    localparam logic [ADDR_W-1:0] A_ZAP1  = ADDR_W'(OFS_ZAP1);
    localparam logic [ADDR_W-1:0] A_RAW   = ADDR_W'(OFS_RAW);
    localparam logic [ADDR_W-1:0] A_ICLR  = ADDR_W'(OFS_ICLR);
    localparam logic [ADDR_W-1:0] A_IMASK = ADDR_W'(OFS_IMASK);
    localparam logic [ADDR_W-1:0] A_ISTAT = ADDR_W'(OFS_ISTAT);
    localparam logic [ADDR_W-1:0] A_GATE  = ADDR_W'(OFS_GATE);

    op_strobe_t ops_w;

    logic                stall_act_w;
    logic                fault_act_w;
    logic                fault_write_w;
    logic [BUS_ID_W-1:0] fault_bus_w;
    logic [REG_W-1:0]    fault_addr_w;
    logic [IRQ_N-1:0]    raw_w;
    logic [IRQ_N-1:0]    mask_w;
    logic [IRQ_N-1:0]    masked_w;
    logic [IRQ_N-1:0]    irq_set_w;

    mmu_csr_cmd #(.ADDR_W(ADDR_W)) u_cmd (
        .wr_en (csr_we),
        .addr  (csr_addr),
        .wdata (csr_wdata),
        .ops   (ops_w)
    );

    mmu_csr_state u_state (
        .clk            (clk),
        .rst_n          (rst_n),
        .ops            (ops_w),
        .ev_fault       (dp_fault),
        .ev_fault_addr  (dp_fault_addr),
        .ev_fault_write (dp_fault_write),
        .ev_bus_id      (dp_fault_bus_id),
        .dp_idle        (dp_idle),
        .paging         (paging_en),
        .stall_want     (stall_req),
        .stall_act      (stall_act_w),
        .fault_act      (fault_act_w),
        .fault_write    (fault_write_w),
        .fault_bus_id   (fault_bus_w),
        .fault_addr     (fault_addr_w),
        .zap_all_p      (zap_all),
        .fault_done_p   (fault_done)
    );

    always_comb begin
        irq_set_w             = '0;
        irq_set_w[IRQ_FAULT]  = dp_fault;
        irq_set_w[IRQ_BUSERR] = dp_bus_err;
    end

    mmu_csr_intr #(.N(IRQ_N)) u_intr (
        .clk       (clk),
        .rst_n     (rst_n),
        .hard_rst  (ops_w.hard_rst),
        .set_ev    (irq_set_w),
        .clr_we    (csr_we && (csr_addr == A_ICLR)),
        .clr_bits  (csr_wdata[IRQ_N-1:0]),
        .mask_we   (csr_we && (csr_addr == A_IMASK)),
        .mask_bits (csr_wdata[IRQ_N-1:0]),
        .raw       (raw_w),
        .mask      (mask_w),
        .masked    (masked_w),
        .irq       (irq)
    );

    // local registers: directory base, gating bit, single-page invalidate
    typedef struct packed {
        logic [PFN_W-1:0] base;
        logic             gate;
        logic             zap1;
        logic [PFN_W-1:0] zap1_page;
    } loc_t;

    loc_t lc_d, lc_q;

    always_comb begin
        lc_d      = lc_q;
        lc_d.zap1 = 1'b0;
        if (csr_we) begin
            if (csr_addr == A_BASE) lc_d.base = csr_wdata[REG_W-1:PAGE_SHIFT];
            if (csr_addr == A_GATE) lc_d.gate = csr_wdata[0];
            if (csr_addr == A_ZAP1) begin
                lc_d.zap1      = 1'b1;
                lc_d.zap1_page = csr_wdata[REG_W-1:PAGE_SHIFT];
            end
        end
        if (ops_w.hard_rst) lc_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lc_q <= '0;
        else        lc_q <= lc_d;
    end

    assign zap_one      = lc_q.zap1;
    assign zap_one_page = lc_q.zap1_page;

    logic [REG_W-1:0] stat_w;

    always_comb begin
        stat_w                            = '0;
        stat_w[ST_PAGING]                 = paging_en;
        stat_w[ST_FAULT]                  = fault_act_w;
        stat_w[ST_STALL]                  = stall_act_w;
        stat_w[ST_IDLE]                   = dp_idle;
        stat_w[ST_REPLAY]                 = dp_replay_empty;
        stat_w[ST_FWRITE]                 = fault_write_w;
        stat_w[ST_BUSID +: BUS_ID_W]      = fault_bus_w;
        stat_w[ST_NOSTALL]                = ~stall_act_w;
    end

    always_comb begin
        case (csr_addr)
            A_BASE:  csr_rdata = {lc_q.base, {PAGE_SHIFT{1'b0}}};
            A_STAT:  csr_rdata = stat_w;
            A_FADDR: csr_rdata = fault_addr_w;
            A_RAW:   csr_rdata = REG_W'(raw_w);
            A_IMASK: csr_rdata = REG_W'(mask_w);
            A_ISTAT: csr_rdata = REG_W'(masked_w);
            A_GATE:  csr_rdata = REG_W'(lc_q.gate);
            default: csr_rdata = '0;
        endcase
    end

endmodule

// File: rtl/mmu_csr_chk.sv
module mmu_csr_chk
    import mmu_csr_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              csr_we,
    input logic [ADDR_W-1:0] csr_addr,
    input logic [REG_W-1:0]  csr_wdata,
    input op_strobe_t        ops,
    input logic              dp_fault,
    input logic              dp_idle,
    input logic              paging_en,
    input logic              stall_req,
    input logic              stall_act,
    input logic              fault_act,
    input logic [IRQ_N-1:0]  mask,
    input logic              zap_all,
    input logic              irq
);

    logic cmd_wr;
    assign cmd_wr = csr_we && (csr_addr == ADDR_W'(OFS_CMD));

    // R2: enabling paging takes effect at the accepting edge
    p_paging_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && csr_wdata == REG_W'(OP_PAGE_ON)) |=> paging_en);

    // R3: stall can only be reported while it is requested
    p_stall_needs_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stall_act |-> stall_req);

    // R3: stall becomes active only after an idle datapath was seen
    p_stall_after_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stall_act) |-> $past(dp_idle));

    // R4: no new stall request while a fault is pending
    p_stall_refused_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_act && !stall_req) |=> !stall_req);

    // R5: a fault event always leaves the unit in the fault state
    p_fault_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_fault && !ops.hard_rst) |=> fault_act);

    // R8: interrupt stays low with every cause masked
    p_irq_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq);

    // R9: the invalidate-all strobe only follows its command
    p_zap_from_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        zap_all |-> $past(cmd_wr && csr_wdata == REG_W'(OP_ZAP_ALL)));

endmodule

bind mmu_csr mmu_csr_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .csr_we    (csr_we),
    .csr_addr  (csr_addr),
    .csr_wdata (csr_wdata),
    .ops       (ops_w),
    .dp_fault  (dp_fault),
    .dp_idle   (dp_idle),
    .paging_en (paging_en),
    .stall_req (stall_req),
    .stall_act (stall_act_w),
    .fault_act (fault_act_w),
    .mask      (mask_w),
    .zap_all   (zap_all),
    .irq       (irq)
);

// File: tb/sim_mmu_csr.sv
`timescale 1ns/1ps
module sim_mmu_csr;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_we = 1'b0;
    logic [7:0]  csr_addr = '0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        dp_fault = 1'b0;
    logic [31:0] dp_fault_addr = '0;
    logic        dp_fault_write = 1'b0;
    logic [4:0]  dp_fault_bus_id = '0;
    logic        dp_bus_err = 1'b0;
    logic        dp_idle = 1'b0;
    logic        dp_replay_empty = 1'b0;
    logic        paging_en, stall_req, zap_all, zap_one, fault_done, irq;
    logic [19:0] zap_one_page;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    mmu_csr u0 (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .dp_fault(dp_fault),
        .dp_fault_addr(dp_fault_addr), .dp_fault_write(dp_fault_write),
        .dp_fault_bus_id(dp_fault_bus_id), .dp_bus_err(dp_bus_err),
        .dp_idle(dp_idle), .dp_replay_empty(dp_replay_empty),
        .paging_en(paging_en), .stall_req(stall_req), .zap_all(zap_all),
        .zap_one(zap_one), .zap_one_page(zap_one_page),
        .fault_done(fault_done), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        csr_we = 1'b1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        csr_addr = a;
        #1;
        d = csr_rdata;
    endtask

    task automatic fault_ev(input logic [31:0] a, input logic w, input logic [4:0] id);
        @(negedge clk);
        dp_fault = 1'b1; dp_fault_addr = a; dp_fault_write = w; dp_fault_bus_id = id;
        @(negedge clk);
        dp_fault = 1'b0;
    endtask

    function automatic logic [1:0] exp_raw(input logic [1:0] raw, input logic [1:0] ev,
                                           input bit clr, input logic [1:0] cb);
        return (raw & ~(clr ? cb : 2'b00)) | ev;
    endfunction

    function automatic logic [31:0] exp_masked(input logic [1:0] raw, input logic [1:0] m);
        return {30'b0, raw & m};
    endfunction

    initial begin
        #(5.0 * 20000);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual running expected done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [1:0]  m_raw, m_mask;
        void'($urandom(32'd1789));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        rd(8'h00, r); chk("R1 base reset", r, 32'h0);
        rd(8'h04, r); chk("R3 status reset", r, 32'h8000_0000);
        chk("R2 paging reset", {31'b0, paging_en}, 32'h0);
        chk("R8 irq reset", {31'b0, irq}, 32'h0);

        // R1 base masking
        wr(8'h00, 32'hCAFE_BABE);
        rd(8'h00, r); chk("R1 base low bits", r, 32'hCAFE_B000);

        // R2 paging on/off
        wr(8'h08, 32'd0);
        chk("R2 paging on out", {31'b0, paging_en}, 32'h1);
        rd(8'h04, r); chk("R2 status bit0 on", {31'b0, r[0]}, 32'h1);
        wr(8'h08, 32'd1);
        chk("R2 paging off", {31'b0, paging_en}, 32'h0);
        wr(8'h08, 32'd0);

        // R11 undefined commands
        wr(8'h08, 32'd7);
        wr(8'h08, 32'h0000_0100);
        chk("R11 paging kept", {31'b0, paging_en}, 32'h1);
        chk("R11 no stall", {31'b0, stall_req}, 32'h0);
        chk("R11 no zap", {31'b0, zap_all}, 32'h0);

        // R3 stall handshake
        dp_idle = 1'b0;
        wr(8'h08, 32'd2);
        chk("R3 stall_req", {31'b0, stall_req}, 32'h1);
        rd(8'h04, r); chk("R3 not active busy", {r[31], r[2]}, 32'h2);
        @(negedge clk);
        rd(8'h04, r); chk("R3 still busy", {r[31], r[2]}, 32'h2);
        dp_idle = 1'b1;
        @(negedge clk);
        rd(8'h04, r); chk("R3 active after idle", {r[31], r[2]}, 32'h1);
        chk("R12 idle bit", {31'b0, r[3]}, 32'h1);
        dp_replay_empty = 1'b1;
        rd(8'h04, r); chk("R12 replay bit", {31'b0, r[4]}, 32'h1);
        wr(8'h08, 32'd3);
        chk("R3 stall off", {31'b0, stall_req}, 32'h0);
        rd(8'h04, r); chk("R3 bit31 back", {r[31], r[2]}, 32'h2);

        // R5 fault capture
        fault_ev(32'h1234_5678, 1'b1, 5'h15);
        rd(8'h04, r);
        chk("R5 fault active", {31'b0, r[1]}, 32'h1);
        chk("R5 write flag", {31'b0, r[5]}, 32'h1);
        chk("R5 bus id", {27'b0, r[10:6]}, 32'h15);
        rd(8'h0C, r); chk("R5 fault addr", r, 32'h1234_5678);
        rd(8'h14, r); chk("R5 raw bit0", r, 32'h1);

        // R4 stall refused during fault
        wr(8'h08, 32'd2);
        chk("R4 stall refused", {31'b0, stall_req}, 32'h0);

        // R6 fault done
        wr(8'h08, 32'd5);
        chk("R6 done pulse", {31'b0, fault_done}, 32'h1);
        rd(8'h04, r); chk("R6 fault cleared", {31'b0, r[1]}, 32'h0);
        @(negedge clk);
        chk("R6 pulse ends", {31'b0, fault_done}, 32'h0);
        wr(8'h08, 32'd2);
        chk("R4 stall honoured after done", {31'b0, stall_req}, 32'h1);
        wr(8'h08, 32'd3);

        // R9 invalidates
        wr(8'h08, 32'd4);
        chk("R9 zap_all pulse", {31'b0, zap_all}, 32'h1);
        @(negedge clk);
        chk("R9 zap_all ends", {31'b0, zap_all}, 32'h0);
        wr(8'h10, 32'hABCD_E123);
        chk("R9 zap_one pulse", {31'b0, zap_one}, 32'h1);
        chk("R9 zap page", {12'b0, zap_one_page}, 32'h000A_BCDE);
        @(negedge clk);
        chk("R9 zap_one ends", {31'b0, zap_one}, 32'h0);

        // R8 / R7 masking and clearing
        wr(8'h1C, 32'h3);
        chk("R8 irq on", {31'b0, irq}, 32'h1);
        rd(8'h20, r); chk("R8 masked", r, 32'h1);
        wr(8'h18, 32'h1);
        rd(8'h14, r); chk("R7 raw cleared", r, 32'h0);
        chk("R8 irq off", {31'b0, irq}, 32'h0);

        // R10 hard reset
        wr(8'h24, 32'h1);
        fault_ev(32'hDEAD_0000, 1'b0, 5'h3);
        wr(8'h08, 32'd6);
        rd(8'h00, r); chk("R10 base", r, 32'h0);
        rd(8'h0C, r); chk("R10 fault addr", r, 32'h0);
        rd(8'h14, r); chk("R10 raw", r, 32'h0);
        rd(8'h1C, r); chk("R10 mask", r, 32'h0);
        rd(8'h24, r); chk("R10 gate", r, 32'h0);
        rd(8'h04, r); chk("R10 status", r & 32'h8000_07E7, 32'h8000_0000);
        chk("R10 paging", {31'b0, paging_en}, 32'h0);

        // R7 / R8 random mix of events, clears and mask writes
        m_raw = 2'b00; m_mask = 2'b00;
        for (int i = 0; i < 400; i++) begin
            logic [1:0] ev, bits;
            int act;
            ev   = 2'($urandom_range(0, 3));
            bits = 2'($urandom_range(0, 3));
            act  = $urandom_range(0, 2);
            @(negedge clk);
            dp_fault   = ev[0];
            dp_bus_err = ev[1];
            dp_fault_addr = $urandom;
            csr_we    = (act != 0);
            csr_addr  = (act == 2) ? 8'h1C : 8'h18;
            csr_wdata = {30'b0, bits};
            @(negedge clk);
            dp_fault = 1'b0; dp_bus_err = 1'b0; csr_we = 1'b0;
            m_raw = exp_raw(m_raw, ev, act == 1, bits);
            if (act == 2) m_mask = bits;
            rd(8'h14, r); chk("R7 raw random", r, {30'b0, m_raw});
            rd(8'h20, r); chk("R8 masked random", r, exp_masked(m_raw, m_mask));
            chk("R8 irq random", {31'b0, irq}, {31'b0, |(m_raw & m_mask)});
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule